// File: doc/BRIEF.md
# Programming-Mode Address Counter with Access Protection

This block keeps the 14-bit word counter that steps through memory while a device is in serial programming mode. The counter starts in user space and stays there until a command moves it into configuration space. From the counter value the block derives the physical word address for either memory. It also flags whether a read must return zeros and whether a write may go ahead. The memory array, the serial pin protocol and any checksum logic live elsewhere. This block only sequences the address and gates access to it.

Entering programming mode is modelled by the active-low reset. A one-cycle increment pulse advances the counter. A one-cycle load-configuration pulse moves it into configuration space, and it then stays there until the next reset. Each configuration bit reads 1 when unprogrammed and 0 when programmed. Protection is on when the relevant bits are 0, and any mixed pattern of program-protect bits counts as protected, so a bad pattern fails safe. All outputs are combinational from the counter register and the configuration-word input. They therefore show the new address in the cycle after the edge that moved the counter.

Top module: `pgm_addr_ctrl`

## Requirements
- R1: While rst_n is low, and in the first cycle after it has been low at a clock edge, the counter is 0x0000: phys_addr_o is 0 and cfg_sel_o is 0.
- R2: In user space (counter below 0x2000), an increment pulse without load-configuration adds one to the counter, with 0x1FFF wrapping to 0x0000. With neither pulse present, the counter holds its value.
- R3: A load-configuration pulse sets the counter to 0x2000 whether or not increment is also high. After that, cfg_sel_o stays 1 until reset, and increments wrap from 0x3FFF back to 0x2000.
- R4: In user space, phys_addr_o is the low 12 bits of the counter, so 0x1000 and above alias onto 0x000–0xFFF.
- R5: In configuration space, phys_addr_o is the low 8 bits of the counter with the upper 4 bits zero, so 0x2100 and above alias back onto offsets 0x00–0xFF.
- R6: For a user-space physical address below 0xFC0 (program region), access is open only when cfg_word_i bits 13,12 are both 1 and bits 5,4 are both 1; open means rd_zero_o=0 and wr_en_o=1. Any other value of those four bits, including 01 or 10 in a pair, gives rd_zero_o=1 and wr_en_o=0.
- R7: For a user-space physical address of 0xFC0–0xFFF (calibration region), rd_zero_o is 0. wr_en_o is 1 only when cfg_word_i bits 8 and 7 are both 1.
- R8: In configuration space, rd_zero_o is always 0. wr_en_o is 1 only at window offsets 0x00–0x03 (identification words) and 0x07 (configuration word), and 0 at every other offset, whatever cfg_word_i holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; programming-mode entry |
| inc_i | input | 1 | One-cycle pulse that advances the counter |
| ld_cfg_i | input | 1 | One-cycle pulse that moves the counter to 0x2000 |
| cfg_word_i | input | 14 | Current configuration word; 0 means programmed |
| phys_addr_o | output | 12 | Physical word address in the selected memory |
| cfg_sel_o | output | 1 | 1 when configuration memory is selected |
| rd_zero_o | output | 1 | 1 when a read of this address must return zeros |
| wr_en_o | output | 1 | 1 when a write to this address is permitted |

## Verification
A wrong counter value shows on phys_addr_o in the cycle after the edge that produced it. Only counter bit 12, and bits 11 to 8 while in configuration space, stay hidden. Those bits come out later, when the count reaches a wrap point and the next address is not the expected 0x0000 or 0x2000. A configuration-space flag that is lost or set by mistake shows at once on cfg_sel_o, and it also changes the write decision at every offset except 0x00–0x03 and 0x07. A region boundary or protect-bit decode that is off by one shows as a wrong rd_zero_o or wr_en_o only at the address or bit pattern concerned. The bench therefore walks the whole counter range and drives mixed protect patterns.

// File: rtl/pgm_pkg.sv
package pgm_pkg;

  typedef enum logic [1:0] {
    REG_PROG = 2'd0,
    REG_CAL  = 2'd1,
    REG_CFG  = 2'd2
  } region_e;

  // A protect pair is open only when both of its bits are unprogrammed.
  function automatic logic pair_open(input logic [1:0] bits);
    return bits[1] & bits[0];
  endfunction

  // Configuration window slots that accept writes.
  function automatic logic cfg_slot_writable(input int unsigned off,
                                             input int unsigned n_id,
                                             input int unsigned word_slot);
    return (off < n_id) || (off == word_slot);
  endfunction

endpackage

// File: rtl/pgm_counter.sv
module pgm_counter #(
  parameter int PC_W = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inc_i,
  input  logic            ld_cfg_i,
  output logic [PC_W-1:0] pc_o
);
  localparam int LOW_W = PC_W - 1;

  logic [PC_W-1:0] pc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else if (ld_cfg_i) begin
      pc_q <= {1'b1, {LOW_W{1'b0}}};
    end else if (inc_i) begin
      // Top bit is kept, so each half wraps onto its own base.
      pc_q <= {pc_q[PC_W-1], pc_q[LOW_W-1:0] + {{(LOW_W-1){1'b0}}, 1'b1}};
    end
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/pgm_mapper.sv
module pgm_mapper
  import pgm_pkg::*;
#(
  parameter int PC_W     = 14,
  parameter int USER_AW  = 12,
  parameter int CFG_AW   = 8,
  parameter int CAL_BASE = 4032
) (
  input  logic [PC_W-1:0]    pc_i,
  output logic [USER_AW-1:0] phys_o,
  output logic [CFG_AW-1:0]  cfg_off_o,
  output region_e            region_o
);
  localparam logic [USER_AW-1:0] CAL_LIM = USER_AW'(CAL_BASE);

  logic               in_cfg;
  logic [USER_AW-1:0] user_off;
  logic [USER_AW-1:0] cfg_wide;
  logic               unused_pc_bits;

  assign in_cfg    = pc_i[PC_W-1];
  assign user_off  = pc_i[USER_AW-1:0];
  assign cfg_off_o = pc_i[CFG_AW-1:0];
  assign unused_pc_bits = ^pc_i;

  generate
    if (CFG_AW == USER_AW) begin : g_same_w
      assign cfg_wide = cfg_off_o;
    end else begin : g_pad_w
      assign cfg_wide = {{(USER_AW-CFG_AW){1'b0}}, cfg_off_o};
    end
  endgenerate

  assign phys_o = in_cfg ? cfg_wide : user_off;

  always_comb begin
    if (in_cfg)                   region_o = REG_CFG;
    else if (user_off >= CAL_LIM) region_o = REG_CAL;
    else                          region_o = REG_PROG;
  end
endmodule

// File: rtl/pgm_gate.sv
module pgm_gate
  import pgm_pkg::*;
#(
  parameter int CW_W      = 14,
  parameter int CFG_AW    = 8,
  parameter int PPA_HI    = 13,
  parameter int PPB_HI    = 5,
  parameter int CP_HI     = 8,
  parameter int N_ID      = 4,
  parameter int WORD_SLOT = 7
) (
  input  region_e           region_i,
  input  logic [CFG_AW-1:0] cfg_off_i,
  input  logic [CW_W-1:0]   cfg_word_i,
  output logic              prog_open_o,
  output logic              cal_open_o,
  output logic              rd_zero_o,
  output logic              wr_en_o
);
  logic slot_ok;
  logic unused_cw_bits;

  assign unused_cw_bits = ^cfg_word_i;
  assign prog_open_o = pair_open(cfg_word_i[PPA_HI -: 2]) &
                       pair_open(cfg_word_i[PPB_HI -: 2]);
  assign cal_open_o  = pair_open(cfg_word_i[CP_HI -: 2]);
  assign slot_ok     = cfg_slot_writable(int'(cfg_off_i), N_ID, WORD_SLOT);

  always_comb begin
    rd_zero_o = 1'b0;
    wr_en_o   = 1'b0;
    case (region_i)
      REG_PROG: begin
        rd_zero_o = ~prog_open_o;
        wr_en_o   = prog_open_o;
      end
      REG_CAL:  wr_en_o = cal_open_o;
      REG_CFG:  wr_en_o = slot_ok;
      default:  wr_en_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pgm_addr_ctrl.sv
module pgm_addr_ctrl
  import pgm_pkg::*;
#(
  parameter int PC_W     = 14,
  parameter int USER_AW  = 12,
  parameter int CFG_AW   = 8,
  parameter int CAL_BASE = 4032,
  parameter int CW_W     = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inc_i,
  input  logic               ld_cfg_i,
  input  logic [CW_W-1:0]    cfg_word_i,
  output logic [USER_AW-1:0] phys_addr_o,
  output logic               cfg_sel_o,
  output logic               rd_zero_o,
  output logic               wr_en_o
);
  logic [PC_W-1:0]   pc_w;
  logic [CFG_AW-1:0] cfg_off_w;
  region_e           region_w;
  logic              prog_open_w;
  logic              cal_open_w;

  pgm_counter #(.PC_W(PC_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc_i(inc_i), .ld_cfg_i(ld_cfg_i), .pc_o(pc_w)
  );

  pgm_mapper #(.PC_W(PC_W), .USER_AW(USER_AW), .CFG_AW(CFG_AW),
               .CAL_BASE(CAL_BASE)) u_map (
    .pc_i(pc_w), .phys_o(phys_addr_o), .cfg_off_o(cfg_off_w), .region_o(region_w)
  );

  pgm_gate #(.CW_W(CW_W), .CFG_AW(CFG_AW)) u_gate (
    .region_i(region_w), .cfg_off_i(cfg_off_w), .cfg_word_i(cfg_word_i),
    .prog_open_o(prog_open_w), .cal_open_o(cal_open_w),
    .rd_zero_o(rd_zero_o), .wr_en_o(wr_en_o)
  );

  assign cfg_sel_o = (region_w == REG_CFG);
endmodule

// File: rtl/pgm_addr_ctrl_chk.sv
module pgm_addr_ctrl_chk #(
  parameter int PC_W    = 14,
  parameter int USER_AW = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               inc_i,
  input logic               ld_cfg_i,
  input logic [PC_W-1:0]    pc_i,
  input logic [1:0]         region_i,
  input logic               prog_open_i,
  input logic [USER_AW-1:0] phys_addr_o,
  input logic               cfg_sel_o,
  input logic               rd_zero_o,
  input logic               wr_en_o
);
  AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !ld_cfg_i) |=> pc_i[PC_W-2:0] == $past(pc_i[PC_W-2:0]) + 1'b1); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_i && !ld_cfg_i) |=> $stable(pc_i)); // R2
  AST_LOAD_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_cfg_i |=> (cfg_sel_o && phys_addr_o == '0)); // R3
  AST_CFG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_sel_o |=> cfg_sel_o); // R3
  AST_HALF_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !ld_cfg_i) |=> pc_i[PC_W-1] == $past(pc_i[PC_W-1])); // R3
  AST_CFG_NO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_sel_o |-> !rd_zero_o); // R8
  AST_ZERO_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_zero_o |-> (!wr_en_o && !prog_open_i && region_i == 2'd0)); // R6
  AST_CAL_READS: assert property (@(posedge clk) disable iff (!rst_n)
    (region_i == 2'd1) |-> !rd_zero_o); // R7
endmodule

bind pgm_addr_ctrl pgm_addr_ctrl_chk #(.PC_W(PC_W), .USER_AW(USER_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .inc_i(inc_i), .ld_cfg_i(ld_cfg_i),
  .pc_i(pc_w), .region_i(region_w), .prog_open_i(prog_open_w),
  .phys_addr_o(phys_addr_o), .cfg_sel_o(cfg_sel_o),
  .rd_zero_o(rd_zero_o), .wr_en_o(wr_en_o)
);

// File: tb/tb_pgm_addr_ctrl.sv
`timescale 1ns/1ps
module tb_pgm_addr_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inc_i = 1'b0;
  logic        ld_cfg_i = 1'b0;
  logic [13:0] cfg_word_i = 14'h3FFF;
  logic [11:0] phys_addr_o;
  logic        cfg_sel_o, rd_zero_o, wr_en_o;

  always #2 clk = ~clk;

  pgm_addr_ctrl dut (
    .clk(clk), .rst_n(rst_n), .inc_i(inc_i), .ld_cfg_i(ld_cfg_i),
    .cfg_word_i(cfg_word_i), .phys_addr_o(phys_addr_o), .cfg_sel_o(cfg_sel_o),
    .rd_zero_o(rd_zero_o), .wr_en_o(wr_en_o)
  );

  typedef struct {
    logic [11:0] phys;
    logic        cfg;
    logic        rz;
    logic        we;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  int   mpc   = 0;
  bit   done  = 1'b0;

  function automatic exp_t expect_of(int p, logic [13:0] w, string tag);
    exp_t e;
    bit   popen, copen;
    int   off;
    popen = w[13] && w[12] && w[5] && w[4];
    copen = w[8] && w[7];
    e.tag = tag;
    if (p >= 'h2000) begin
      off    = p % 256;
      e.phys = 12'(off);
      e.cfg  = 1'b1;
      e.rz   = 1'b0;
      e.we   = (off <= 3) || (off == 7);
    end else begin
      off    = p % 4096;
      e.phys = 12'(off);
      e.cfg  = 1'b0;
      if (off >= 'hFC0) begin
        e.rz = 1'b0;
        e.we = copen;
      end else begin
        e.rz = !popen;
        e.we = popen;
      end
    end
    return e;
  endfunction

  task automatic step(input bit inc, input bit ld, input logic [13:0] w, input string tag);
    @(negedge clk);
    inc_i = inc; ld_cfg_i = ld; cfg_word_i = w;
    if (ld) mpc = 'h2000;
    else if (inc) begin
      if (mpc >= 'h2000) mpc = 'h2000 + ((mpc + 1) % 'h2000);
      else mpc = (mpc + 1) % 'h2000;
    end
    @(posedge clk);
    #1 q.push_back(expect_of(mpc, w, tag));
  endtask

  task automatic do_reset(input logic [13:0] w);
    @(negedge clk);
    rst_n = 1'b0; inc_i = 1'b0; ld_cfg_i = 1'b0; cfg_word_i = w;
    mpc = 0;
    @(posedge clk);
    #1 q.push_back(expect_of(0, w, "R1"));
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_to(input int target, input logic [13:0] w, input string tag);
    while (mpc != target) step(1'b1, 1'b0, w, tag);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #2;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_vec++;
        if (phys_addr_o !== e.phys || cfg_sel_o !== e.cfg ||
            rd_zero_o !== e.rz || wr_en_o !== e.we) begin
          n_bad++;
          $display("FAIL %s: got phys=%h cfg=%b rz=%b we=%b, expected phys=%h cfg=%b rz=%b we=%b",
                   e.tag, phys_addr_o, cfg_sel_o, rd_zero_o, wr_en_o,
                   e.phys, e.cfg, e.rz, e.we);
        end
      end
    end
  end

  initial begin : watchdog
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : main
    @(posedge clk);
    #1 q.push_back(expect_of(0, 14'h3FFF, "R1"));   // R1 reset state
    do_reset(14'h3FFF);
    step(1'b0, 1'b0, 14'h3FFF, "R2");                 // R2 hold
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 14'h3FFF, "R2");
    step(1'b0, 1'b0, 14'h0000, "R6");                 // R6 fully protected
    step(1'b0, 1'b0, 14'h2FFF, "R6");                 // R6 pair A = 10
    step(1'b0, 1'b0, 14'h3FEF, "R6");                 // R6 pair B = 10
    step(1'b0, 1'b0, 14'h1FFF, "R6");                 // R6 pair A = 01
    step(1'b0, 1'b0, 14'h3FFF, "R6");                 // R6 open
    run_to('hFBF, 14'h3FFF, "R4");
    step(1'b1, 1'b0, 14'h3FFF, "R7");                 // R7 first calibration word
    step(1'b0, 1'b0, 14'h3F7F, "R7");                 // R7 bit 7 programmed
    step(1'b0, 1'b0, 14'h3EFF, "R7");                 // R7 bit 8 programmed
    step(1'b0, 1'b0, 14'h0000, "R7");                 // R7 reads normally
    run_to('hFFF, 14'h3FFF, "R7");
    step(1'b1, 1'b0, 14'h0000, "R4");                 // R4 alias 0x1000 -> 0x000
    run_to('h1FFF, 14'h3FFF, "R4");
    step(1'b1, 1'b0, 14'h3FFF, "R2");                 // R2 wrap to 0x0000
    step(1'b1, 1'b1, 14'h0000, "R3");                 // R3 load wins over inc
    for (int i = 0; i < 9; i++) step(1'b1, 1'b0, 14'h0000, "R8");
    step(1'b0, 1'b0, 14'h3FFF, "R8");
    run_to('h20FF, 14'h3FFF, "R5");
    step(1'b1, 1'b0, 14'h3FFF, "R5");                 // R5 alias 0x2100 -> offset 0
    run_to('h3FFF, 14'h0000, "R5");
    step(1'b1, 1'b0, 14'h3FFF, "R3");                 // R3 wrap to 0x2000
    step(1'b1, 1'b1, 14'h3FFF, "R3");                 // R3 reload stays in config
    do_reset(14'h3FFF);                               // R1 mid-run reset
    step(1'b1, 1'b0, 14'h3FFF, "R2");
    step(1'b0, 1'b0, 14'h3FFF, "R2");
    @(posedge clk);
    #4;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule